// File: doc/BRIEF.md
# Calendar Time Counter with BCD/Binary Encoding and Daylight-Saving Jumps

This block keeps the wall-clock time and date of a real-time clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each pulse on the one-second update strobe moves the time forward by one second. Carries ripple from seconds up through the year. Month lengths follow the calendar, and February gains its 29th day in years divisible by four.

Three plain mode pins shape what software sees. One picks BCD or binary for every field. One picks 12-hour or 24-hour hours. One turns on the automatic daylight-saving jumps. All three act on the outputs in the same cycle and are never changed by reset. While the hold pin is high the counter freezes, and software loads fields through a one-cycle write port. The port has no back-pressure: every write made while the hold pin is high is accepted on that clock edge. Writes made while the hold pin is low are dropped. A written value uses the same encoding and hour format as the outputs.

Internally every field is stored in binary and the hours always run 0 to 23. Encoding happens at the outputs, and decoding happens on the write path.

Top module: `cal_counter`

## Requirements
- R1: After a synchronous active-low reset the outputs show 00:00:00 in 24-hour mode, day of week 1, date 1, month 1 and year 0.
- R2: Each strobe taken while hold is low advances one second. Seconds and minutes carry at 59 and hours at 23. Years run 0..99 and wrap to 0 after 99, which also wraps December 31 to January 1.
- R3: Day of month carries to 1 after day 30 in months 4, 6, 9 and 11 and after day 31 in the other months. In February it carries after day 29 when the year is divisible by four and after day 28 otherwise.
- R4: Day of week counts 1..7 with 1 meaning Sunday. It steps at each midnight and goes from 7 to 1.
- R5: With bin_mode 0 every output field is BCD, with tens in bits 7:4 and units in bits 3:0. With bin_mode 1 it is plain binary. The write data uses the same encoding, and a change of bin_mode shows on the outputs in the same cycle.
- R6: With hr24 1 the hour is 0..23. With hr24 0 the hour reads 12, 1, ..., 11, and bit 7 set marks PM: 12 AM is internal hour 0 and 12 PM is internal hour 12. A write made in 12-hour mode is decoded the same way.
- R7: While set_mode is 1, strobes are ignored, and a write with wr_en 1 loads wr_data into the field named by wr_sel: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Code 7 loads nothing.
- R8: While set_mode is 0, writes have no effect, and with no strobe all fields hold.
- R9: With dse 1, a strobe at 01:59:59 on a Sunday in month 4 with date 1..7 gives 03:00:00. With dse 0, on another weekday or on a later date, the result is 02:00:00.
- R10: With dse 1, a strobe at 01:59:59 on a Sunday in month 10 with date 25..31 gives 01:00:00 and sets an internal once-flag. While that flag is set the next pass through 01:59:59 goes on to 02:00:00. The flag clears in any cycle whose month is not 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-second update strobe |
| set_mode | input | 1 | Hold counting and enable field writes |
| bin_mode | input | 1 | 0 = BCD fields, 1 = binary fields |
| hr24 | input | 1 | 0 = 12-hour with PM in bit 7, 1 = 24-hour |
| dse | input | 1 | Enable daylight-saving jumps |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write value in the current encoding |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week, 1 = Sunday |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year 0..99 |

## Verification
The hardest state to reach from the ports is the repeated hour after the autumn jump. The once-flag must stop a second jump when 01:59:59 comes round again, so the second pass has to be observed. The stimulus writes a late-October Sunday at 01:59:58 and takes the jump. It then drives 3600 further strobes through the whole repeated hour, so the model checks the second pass, and the flag is cleared by leaving October and coming back. The leap-day and year-wrap carries are reached by writing the instant just before midnight and applying one strobe.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FW   = 7;
  localparam int NFLD = 7;

  localparam logic [FW-1:0] ZERO = 7'd0;
  localparam logic [FW-1:0] ONE  = 7'd1;
  localparam logic [FW-1:0] TEN  = 7'd10;
  localparam logic [FW-1:0] TWELVE = 7'd12;

  localparam logic [FW-1:0] SEC_LAST  = 7'd59;
  localparam logic [FW-1:0] MIN_LAST  = 7'd59;
  localparam logic [FW-1:0] HOUR_LAST = 7'd23;
  localparam logic [FW-1:0] WDAY_LAST = 7'd7;
  localparam logic [FW-1:0] MON_LAST  = 7'd12;
  localparam logic [FW-1:0] YEAR_LAST = 7'd99;

  localparam logic [FW-1:0] SUNDAY          = 7'd1;
  localparam logic [FW-1:0] SPRING_MON      = 7'd4;
  localparam logic [FW-1:0] FALL_MON        = 7'd10;
  localparam logic [FW-1:0] SPRING_MAX_DATE = 7'd7;
  localparam logic [FW-1:0] FALL_MIN_DATE   = 7'd25;
  localparam logic [FW-1:0] DST_HOUR        = 7'd1;
  localparam logic [FW-1:0] SPRING_TO_HOUR  = 7'd3;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_MDAY = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } fld_e;

  function automatic logic [7:0] to_bcd(input logic [FW-1:0] v);
    logic [FW-1:0] tens;
    logic [FW-1:0] ones;
    tens = v / TEN;
    ones = v - tens * TEN;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [FW-1:0] from_bcd(input logic [7:0] b);
    return FW'(b[7:4]) * TEN + FW'(b[3:0]);
  endfunction

  function automatic logic [FW-1:0] days_in_month(input logic [FW-1:0] m,
                                                   input logic leap);
    case (m)
      7'd2:                      return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_codec.sv
module cal_codec
  import cal_pkg::*;
(
  input  logic [FW-1:0] val,
  input  logic          bin_mode,
  input  logic          flag,
  output logic [7:0]    code
);
  logic [7:0] body;

  always_comb begin
    body = bin_mode ? {1'b0, val} : to_bcd(val);
    code = body | {flag, 7'b0};
  end
endmodule

// File: rtl/cal_wr_decode.sv
module cal_wr_decode
  import cal_pkg::*;
(
  input  logic [7:0]    wr_data,
  input  logic [2:0]    wr_sel,
  input  logic          bin_mode,
  input  logic          hr24,
  output logic [FW-1:0] wr_val
);
  logic [7:0]    raw;
  logic [FW-1:0] dec;
  logic          twelve_hr;

  always_comb begin
    twelve_hr = (wr_sel == F_HOUR) && !hr24;
    raw       = twelve_hr ? {1'b0, wr_data[6:0]} : wr_data;
    dec       = bin_mode ? raw[FW-1:0] : from_bcd(raw);
    if (twelve_hr) begin
      wr_val = (dec == TWELVE) ? ZERO : dec;
      if (wr_data[7]) wr_val = wr_val + TWELVE;
    end else begin
      wr_val = dec;
    end
  end
endmodule

// File: rtl/cal_dst_rule.sv
module cal_dst_rule
  import cal_pkg::*;
(
  input  logic          dse,
  input  logic          fell_q,
  input  logic [FW-1:0] sec_q,
  input  logic [FW-1:0] min_q,
  input  logic [FW-1:0] hour_q,
  input  logic [FW-1:0] wday_q,
  input  logic [FW-1:0] mday_q,
  input  logic [FW-1:0] mon_q,
  output logic          spring_hit,
  output logic          fall_hit
);
  logic at_edge;
  logic sunday;

  always_comb begin
    at_edge    = (hour_q == DST_HOUR) && (min_q == MIN_LAST) && (sec_q == SEC_LAST);
    sunday     = (wday_q == SUNDAY);
    spring_hit = dse && at_edge && sunday && (mon_q == SPRING_MON) &&
                 (mday_q <= SPRING_MAX_DATE);
    fall_hit   = dse && at_edge && sunday && (mon_q == FALL_MON) &&
                 (mday_q >= FALL_MIN_DATE) && !fell_q;
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          wr_ok,
  input  logic [2:0]    wr_sel,
  input  logic [FW-1:0] wr_val,
  input  logic          spring_hit,
  input  logic          fall_hit,
  output logic [FW-1:0] sec_q,
  output logic [FW-1:0] min_q,
  output logic [FW-1:0] hour_q,
  output logic [FW-1:0] wday_q,
  output logic [FW-1:0] mday_q,
  output logic [FW-1:0] mon_q,
  output logic [FW-1:0] year_q,
  output logic          fell_q
);
  logic [FW-1:0] n_sec, n_min, n_hour, n_wday, n_mday, n_mon, n_year;
  logic          n_fell;
  logic [FW-1:0] dim;
  logic          c_min, c_hr, c_day, c_mon, c_yr;

  assign dim = days_in_month(mon_q, year_q[1:0] == 2'b00);

  always_comb begin
    n_sec  = sec_q;
    n_min  = min_q;
    n_hour = hour_q;
    n_wday = wday_q;
    n_mday = mday_q;
    n_mon  = mon_q;
    n_year = year_q;
    c_min  = 1'b0;
    c_hr   = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_yr   = 1'b0;
    if (adv) begin
      if (spring_hit) begin
        n_hour = SPRING_TO_HOUR;
        n_min  = ZERO;
        n_sec  = ZERO;
      end else if (fall_hit) begin
        n_hour = DST_HOUR;
        n_min  = ZERO;
        n_sec  = ZERO;
      end else begin
        c_min = (sec_q >= SEC_LAST);
        n_sec = c_min ? ZERO : sec_q + ONE;
        c_hr  = c_min && (min_q >= MIN_LAST);
        if (c_min) n_min = c_hr ? ZERO : min_q + ONE;
        c_day = c_hr && (hour_q >= HOUR_LAST);
        if (c_hr) n_hour = c_day ? ZERO : hour_q + ONE;
        c_mon = c_day && (mday_q >= dim);
        if (c_day) begin
          n_wday = (wday_q >= WDAY_LAST) ? ONE : wday_q + ONE;
          n_mday = c_mon ? ONE : mday_q + ONE;
        end
        c_yr = c_mon && (mon_q >= MON_LAST);
        if (c_mon) n_mon = c_yr ? ONE : mon_q + ONE;
        if (c_yr) n_year = (year_q >= YEAR_LAST) ? ZERO : year_q + ONE;
      end
    end else if (wr_ok) begin
      case (wr_sel)
        F_SEC:   n_sec  = wr_val;
        F_MIN:   n_min  = wr_val;
        F_HOUR:  n_hour = wr_val;
        F_WDAY:  n_wday = wr_val;
        F_MDAY:  n_mday = wr_val;
        F_MON:   n_mon  = wr_val;
        F_YEAR:  n_year = wr_val;
        default: ;
      endcase
    end
    if (adv && fall_hit) n_fell = 1'b1;
    else if (mon_q != FALL_MON) n_fell = 1'b0;
    else n_fell = fell_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= ZERO;
      min_q  <= ZERO;
      hour_q <= ZERO;
      wday_q <= ONE;
      mday_q <= ONE;
      mon_q  <= ONE;
      year_q <= ZERO;
      fell_q <= 1'b0;
    end else begin
      sec_q  <= n_sec;
      min_q  <= n_min;
      hour_q <= n_hour;
      wday_q <= n_wday;
      mday_q <= n_mday;
      mon_q  <= n_mon;
      year_q <= n_year;
      fell_q <= n_fell;
    end
  end

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !spring_hit && !fall_hit && sec_q < SEC_LAST) |=> (sec_q == $past(sec_q) + ONE));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_ok) |=> $stable({sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q}));

  // R9
  spring_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && spring_hit) |=> (hour_q == SPRING_TO_HOUR && min_q == ZERO && sec_q == ZERO));

  // R10
  fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fall_hit) |=> (fell_q && hour_q == DST_HOUR && min_q == ZERO));

  // R10
  fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_q != FALL_MON && !(adv && fall_hit)) |=> !fell_q);
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic       dse,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  logic [FW-1:0] sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q;
  logic          fell_q;
  logic [FW-1:0] wr_val;
  logic          spring_hit, fall_hit;
  logic          adv, wr_ok;
  logic [FW-1:0] hour_shown;
  logic          pm;

  assign adv   = tick && !set_mode;
  assign wr_ok = wr_en && set_mode;

  cal_wr_decode u_dec (
    .wr_data (wr_data),
    .wr_sel  (wr_sel),
    .bin_mode(bin_mode),
    .hr24    (hr24),
    .wr_val  (wr_val)
  );

  cal_dst_rule u_dst (
    .dse       (dse),
    .fell_q    (fell_q),
    .sec_q     (sec_q),
    .min_q     (min_q),
    .hour_q    (hour_q),
    .wday_q    (wday_q),
    .mday_q    (mday_q),
    .mon_q     (mon_q),
    .spring_hit(spring_hit),
    .fall_hit  (fall_hit)
  );

  cal_time_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .wr_ok     (wr_ok),
    .wr_sel    (wr_sel),
    .wr_val    (wr_val),
    .spring_hit(spring_hit),
    .fall_hit  (fall_hit),
    .sec_q     (sec_q),
    .min_q     (min_q),
    .hour_q    (hour_q),
    .wday_q    (wday_q),
    .mday_q    (mday_q),
    .mon_q     (mon_q),
    .year_q    (year_q),
    .fell_q    (fell_q)
  );

  always_comb begin
    pm = 1'b0;
    hour_shown = hour_q;
    if (!hr24) begin
      pm = (hour_q >= TWELVE);
      if (hour_q == ZERO)       hour_shown = TWELVE;
      else if (hour_q > TWELVE) hour_shown = hour_q - TWELVE;
    end
  end

  logic [FW-1:0] fval  [NFLD];
  logic          fflag [NFLD];
  logic [7:0]    fcode [NFLD];

  always_comb begin
    fval[F_SEC]  = sec_q;
    fval[F_MIN]  = min_q;
    fval[F_HOUR] = hour_shown;
    fval[F_WDAY] = wday_q;
    fval[F_MDAY] = mday_q;
    fval[F_MON]  = mon_q;
    fval[F_YEAR] = year_q;
    for (int i = 0; i < NFLD; i++) fflag[i] = 1'b0;
    fflag[F_HOUR] = pm;
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_codec
    cal_codec u_codec (
      .val     (fval[g]),
      .bin_mode(bin_mode),
      .flag    (fflag[g]),
      .code    (fcode[g])
    );
  end

  assign sec_o  = fcode[F_SEC];
  assign min_o  = fcode[F_MIN];
  assign hour_o = fcode[F_HOUR];
  assign wday_o = fcode[F_WDAY];
  assign mday_o = fcode[F_MDAY];
  assign mon_o  = fcode[F_MON];
  assign year_o = fcode[F_YEAR];

  // R6
  pm_hour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hr24 && bin_mode) |-> (hour_o[6:0] >= 7'd1 && hour_o[6:0] <= 7'd12));
endmodule

// File: tb/test_cal_counter.sv
module test_cal_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, set_mode = 1'b0, bin_mode = 1'b0, hr24 = 1'b1, dse = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

  always #4 clk = ~clk;

  cal_counter i_cal_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .set_mode(set_mode),
    .bin_mode(bin_mode), .hr24(hr24), .dse(dse), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o),
    .year_o(year_o)
  );

  int total = 0, bad = 0;
  bit done = 0;
  string req = "R1";
  int s, m, h, wd, md, mo, yr;
  bit fell;

  function automatic int dim(int mon, int year);
    if (mon == 2) return (year % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int enc(int v);
    return bin_mode ? v : (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int dec(int d);
    return bin_mode ? d : (d / 16) * 10 + (d % 16);
  endfunction

  function automatic int enc_hour(int hv);
    int hh;
    if (hr24) return enc(hv);
    hh = (hv % 12 == 0) ? 12 : hv % 12;
    return enc(hh) + ((hv >= 12) ? 128 : 0);
  endfunction

  task automatic model_reset();
    s = 0; m = 0; h = 0; wd = 1; md = 1; mo = 1; yr = 0; fell = 0;
  endtask

  task automatic model_clock();
    int old_mo;
    bit jumped_fall;
    bit at1;
    int v;
    old_mo = mo;
    jumped_fall = 0;
    if (!set_mode && tick) begin
      at1 = (h == 1 && m == 59 && s == 59);
      if (dse && at1 && wd == 1 && mo == 4 && md <= 7) begin
        h = 3; m = 0; s = 0;
      end else if (dse && at1 && wd == 1 && mo == 10 && md >= 25 && !fell) begin
        h = 1; m = 0; s = 0; jumped_fall = 1;
      end else begin
        s++;
        if (s == 60) begin
          s = 0; m++;
          if (m == 60) begin
            m = 0; h++;
            if (h == 24) begin
              h = 0;
              wd = (wd == 7) ? 1 : wd + 1;
              md++;
              if (md > dim(mo, yr)) begin
                md = 1; mo++;
                if (mo == 13) begin
                  mo = 1;
                  yr = (yr == 99) ? 0 : yr + 1;
                end
              end
            end
          end
        end
      end
    end else if (set_mode && wr_en) begin
      if (wr_sel == 3'd2 && !hr24) begin
        v = dec(wr_data % 128);
        v = (v == 12) ? 0 : v;
        if (wr_data >= 128) v += 12;
        h = v;
      end else begin
        v = dec(wr_data);
        case (wr_sel)
          3'd0: s = v;
          3'd1: m = v;
          3'd2: h = v;
          3'd3: wd = v;
          3'd4: md = v;
          3'd5: mo = v;
          3'd6: yr = v;
          default: ;
        endcase
      end
    end
    if (jumped_fall) fell = 1;
    else if (old_mo != 10) fell = 0;
  endtask

  task automatic chk(string name, logic [7:0] got, int exp);
    total++;
    if (int'(got) != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, name, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("sec", sec_o, enc(s));
    chk("min", min_o, enc(m));
    chk("hour", hour_o, enc_hour(h));
    chk("wday", wday_o, enc(wd));
    chk("mday", mday_o, enc(md));
    chk("mon", mon_o, enc(mo));
    chk("year", year_o, enc(yr));
  endtask

  task automatic step(input bit t, input bit w, input int sel, input int d);
    tick = t; wr_en = w; wr_sel = 3'(sel); wr_data = 8'(d);
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare_all();
    tick = 0; wr_en = 0;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask

  task automatic wr(int sel, int d);
    step(0, 1, sel, d);
  endtask

  task automatic load(int hh, int mm, int ss, int w, int dd, int mn, int y);
    set_mode = 1;
    wr(2, hh); wr(1, mm); wr(0, ss); wr(3, w); wr(4, dd); wr(5, mn); wr(6, y);
    set_mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    req = "R1"; compare_all();
    step(0, 0, 0, 0);

    // R2 R4: plain seconds, then year/month/day/week wrap at 99-12-31 23:59:58
    req = "R2"; tk(5);
    load('h23, 'h59, 'h58, 'h07, 'h31, 'h12, 'h99);
    req = "R2 R4"; tk(3);

    // R7: strobes ignored while set_mode is high, select 7 loads nothing
    req = "R7"; set_mode = 1; tk(4); wr(7, 'h15); wr(0, 'h42); set_mode = 0;
    // R8: writes ignored while set_mode is low; idle holds
    req = "R8"; wr(0, 'h30); wr(5, 'h07); step(0, 0, 0, 0);

    // R3: leap and non-leap February, 30-day month (binary)
    bin_mode = 1;
    req = "R5"; step(0, 0, 0, 0);
    req = "R3";
    load(23, 59, 59, 3, 28, 2, 24); tk(1);
    load(23, 59, 59, 4, 29, 2, 24); tk(1);
    load(23, 59, 59, 5, 28, 2, 23); tk(1);
    load(23, 59, 59, 6, 30, 4, 23); tk(1);
    load(23, 59, 59, 6, 30, 1, 23); tk(1);
    // R5: encoding follows bin_mode in the same cycle
    req = "R5"; bin_mode = 0; step(0, 0, 0, 0); bin_mode = 1; step(0, 0, 0, 0);
    load(45, 37, 19, 2, 17, 11, 88); bin_mode = 0; step(0, 0, 0, 0); tk(2);

    // R6: 12-hour mode writes and noon/midnight crossings
    req = "R6"; hr24 = 0;
    load('h11, 'h59, 'h59, 'h02, 'h10, 'h05, 'h21); tk(2);
    load('h91, 'h59, 'h59, 'h02, 'h10, 'h05, 'h21); tk(2);
    load('h12, 'h00, 'h00, 'h02, 'h10, 'h05, 'h21); tk(1);
    bin_mode = 1; load(8'h8C, 5, 6, 2, 10, 5, 21); tk(1);
    load(8'h87, 5, 6, 2, 10, 5, 21); tk(1);
    bin_mode = 0; hr24 = 1; step(0, 0, 0, 0);

    // R9: spring forward and its non-trigger cases
    req = "R9"; dse = 1;
    load('h01, 'h59, 'h58, 'h01, 'h05, 'h04, 'h22); tk(2);
    dse = 0; load('h01, 'h59, 'h59, 'h01, 'h05, 'h04, 'h22); tk(1);
    dse = 1; load('h01, 'h59, 'h59, 'h02, 'h05, 'h04, 'h22); tk(1);
    load('h01, 'h59, 'h59, 'h01, 'h08, 'h04, 'h22); tk(1);

    // R10: fall back once, run through the repeated hour, then re-arm
    req = "R10";
    load('h01, 'h59, 'h58, 'h01, 'h28, 'h10, 'h22); tk(2);
    tk(3600); tk(2);
    load('h01, 'h59, 'h59, 'h01, 'h24, 'h10, 'h22); tk(1);
    set_mode = 1; wr(5, 'h11); step(0, 0, 0, 0); wr(5, 'h10); set_mode = 0;
    load('h01, 'h59, 'h59, 'h01, 'h30, 'h10, 'h22); tk(2);
    dse = 0; load('h01, 'h59, 'h59, 'h01, 'h28, 'h11, 'h22); step(0, 0, 0, 0);
    set_mode = 1; wr(5, 'h10); set_mode = 0; tk(1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule